// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block decides whether an incoming Ethernet frame is kept or dropped. Once per frame, the receive path presents the 48-bit destination address with a one-cycle valid strobe. In that same cycle the block compares the address against a programmed station address, the broadcast address and a 64-bit multicast hash filter, and it stores the three raw outcomes. Later, a one-cycle end-of-frame strobe asks for the verdict. The block answers one cycle afterwards with a valid pulse and an accept bit.

An optional external filter can take part in the decision. While its select input is high, external logic may drive a reject line. The block counts that line only during a fixed window of cycles that follows the address strobe. Internal matches and promiscuous mode always win over the external reject. When all internal matching is switched off, the external logic alone decides. When the select input is low, the reject line has no effect.

Top module: `rx_accept_filter`

## Requirements
- R1: While reset is asserted and after it is released, `dec_valid` and `accept` are 0 until the first end-of-frame strobe has been processed.
- R2: A destination address equal to `station_addr` is accepted when `no_station` is 0. When `no_station` is 1, this match has no effect.
- R3: The all-ones destination address is accepted when `no_bcast` is 0. When `no_bcast` is 1, this match has no effect.
- R4: An address with bit 0 set (the multicast bit, the first bit on the wire) is accepted when bit `mc_filter[idx]` is 1. To find `idx`, run CRC-32 over the address: reflected polynomial 0xEDB88320, initial value all ones, address bits fed from bit 0 up to bit 47, and no final inversion. Then `idx` is bits [31:26] of the CRC register. An address with bit 0 clear never hits the hash filter.
- R5: When `promisc` is 1, every frame is accepted, whatever the values of `ext_sel` and `ext_reject`.
- R6: A frame with an internal match (R2, R3 or R4) is accepted even when `ext_sel` is 1 and the external reject was counted.
- R7: Internal matching is disabled when all of these hold: `promisc` is 0, `no_bcast` is 1, `no_station` is 1, and all 64 bits of `mc_filter` are 0. If internal matching is disabled and `ext_sel` is 1, a frame is accepted unless the external reject was counted for it.
- R8: `ext_reject` is counted for a frame only when it is sampled high at one of the first `REJ_WIN` clock edges after the edge that samples `da_valid`, and no later than the edge that samples `frame_end`. Later assertions have no effect on that frame. An assertion at the address edge itself is also ignored.
- R9: When `ext_sel` is 0, `ext_reject` has no effect. A frame with no internal match and `promisc` 0 is rejected.
- R10: When `ext_sel` is 1, internal matching is not disabled and no internal match occurs, the frame is rejected whatever the value of `ext_reject`.
- R11: `dec_valid` is high for exactly the one cycle after each edge that samples `frame_end`. A `da_valid` in the same cycle as `frame_end` starts the next frame without changing the verdict of the frame that is ending. Address comparisons use the inputs sampled with `da_valid`. The mode bits and the all-zero test of `mc_filter` use the inputs sampled with `frame_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| da_valid | input | 1 | Destination address strobe, one cycle per frame |
| da | input | 48 | Destination address; bit 0 is the first bit on the wire |
| station_addr | input | 48 | Programmed station address |
| mc_filter | input | 64 | Multicast hash filter |
| promisc | input | 1 | Accept all frames |
| no_bcast | input | 1 | Suppress the broadcast match |
| no_station | input | 1 | Suppress the station address match |
| ext_sel | input | 1 | Let the external filter take part |
| ext_reject | input | 1 | External reject request, counted inside the window |
| frame_end | input | 1 | End-of-frame strobe that requests the verdict |
| dec_valid | output | 1 | Verdict valid, one cycle |
| accept | output | 1 | Verdict: 1 keeps the frame |

## Verification
Two events can meet in a single cycle. The end-of-frame strobe of one frame can coincide with the address strobe of the next frame, and that same cycle can also carry an external reject. The bench forces this on purpose in two cases. In the first, the ending frame has an internal match and is still inside its window. In the second, the ending frame depends only on the external filter and its window has closed, while a reject arrives at the new address edge. In both cases the bench expects the ending frame to be judged only on its own stored state. It also expects the reject to count for neither frame, and it checks the verdict of the following frame on its own. Random frames place the reject before, at and after the end of the window, and before and after the end-of-frame strobe.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef struct packed {
    logic station;
    logic bcast;
    logic hash;
  } rxf_hits_t;

  localparam logic [31:0] RXF_CRC_POLY = 32'hEDB88320;
endpackage

// File: rtl/rxf_addr_match.sv
module rxf_addr_match
  import rxf_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int FILT_W = 64
) (
  input  logic [ADDR_W-1:0] da,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic [FILT_W-1:0] mc_filter,
  output rxf_hits_t         hits
);
  localparam int IDX_W = $clog2(FILT_W);

  function automatic logic [31:0] addr_crc(input logic [ADDR_W-1:0] a);
    logic [31:0] c;
    logic        fb;
    c = '1;
    for (int i = 0; i < ADDR_W; i++) begin
      fb = c[0] ^ a[i];
      c  = c >> 1;
      if (fb) c = c ^ RXF_CRC_POLY;
    end
    return c;
  endfunction

  logic [31:0]      crc;
  logic [IDX_W-1:0] idx;

  always_comb begin
    crc          = addr_crc(da);
    idx          = crc[31 -: IDX_W];
    hits.station = (da == station_addr);
    hits.bcast   = &da;
    hits.hash    = da[0] & mc_filter[idx];
  end
endmodule

// File: rtl/rxf_reject_window.sv
module rxf_reject_window #(
  parameter int REJ_WIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ext_reject,
  output logic rej_seen
);
  localparam int CW = $clog2(REJ_WIN + 1);
  localparam logic [CW-1:0] WIN_C = CW'(REJ_WIN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          open;

  assign open     = (cnt_q != '0);
  assign rej_seen = flag_q | (open & ext_reject);

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (start) begin
      cnt_d  = WIN_C;
      flag_d = 1'b0;
    end else if (open) begin
      cnt_d  = cnt_q - 1'b1;
      flag_d = flag_q | ext_reject;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  p_win_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == WIN_C));
  p_late_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!open && !start) |=> $stable(flag_q));
  p_win_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= WIN_C);
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      da_valid,
  input  rxf_hits_t hits_in,
  input  logic      frame_end,
  input  logic      promisc,
  input  logic      no_bcast,
  input  logic      no_station,
  input  logic      ext_sel,
  input  logic      filter_zero,
  input  logic      rej_seen,
  output logic      dec_valid,
  output logic      accept
);
  rxf_hits_t hits_q, hits_d;
  logic      valid_d, acc_d, acc_q, valid_q;
  logic      internal_hit, int_disabled;

  always_comb begin
    hits_d       = da_valid ? hits_in : hits_q;
    internal_hit = (hits_q.station & ~no_station) |
                   (hits_q.bcast & ~no_bcast) | hits_q.hash;
    int_disabled = ~promisc & no_bcast & no_station & filter_zero;
    valid_d      = frame_end;
    acc_d        = acc_q;
    if (frame_end)
      acc_d = promisc | internal_hit | (ext_sel & int_disabled & ~rej_seen);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits_q  <= '0;
      valid_q <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      hits_q  <= hits_d;
      valid_q <= valid_d;
      acc_q   <= acc_d;
    end
  end

  assign dec_valid = valid_q;
  assign accept    = acc_q & valid_q;

  p_dec_follows_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> dec_valid);
  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> !dec_valid);
  p_promisc_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && promisc) |=> accept);
  p_hit_overrides_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && hits_q.station && !no_station) |=> accept);
  p_nosel_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !ext_sel && int_disabled) |=> !accept);
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int FILT_W  = 64,
  parameter int REJ_WIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              da_valid,
  input  logic [ADDR_W-1:0] da,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic [FILT_W-1:0] mc_filter,
  input  logic              promisc,
  input  logic              no_bcast,
  input  logic              no_station,
  input  logic              ext_sel,
  input  logic              ext_reject,
  input  logic              frame_end,
  output logic              dec_valid,
  output logic              accept
);
  rxf_hits_t hits;
  logic      rej_seen;
  logic      filter_zero;

  assign filter_zero = ~|mc_filter;

  rxf_addr_match #(.ADDR_W(ADDR_W), .FILT_W(FILT_W)) u_match (
    .da(da), .station_addr(station_addr), .mc_filter(mc_filter), .hits(hits)
  );

  rxf_reject_window #(.REJ_WIN(REJ_WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .start(da_valid),
    .ext_reject(ext_reject), .rej_seen(rej_seen)
  );

  rxf_decide u_dec (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .hits_in(hits),
    .frame_end(frame_end), .promisc(promisc), .no_bcast(no_bcast),
    .no_station(no_station), .ext_sel(ext_sel), .filter_zero(filter_zero),
    .rej_seen(rej_seen), .dec_valid(dec_valid), .accept(accept)
  );

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(frame_end)) |-> !dec_valid);
endmodule

// File: tb/rx_accept_filter_bench.sv
module rx_accept_filter_bench;
  localparam int WIN = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        da_valid, promisc, no_bcast, no_station, ext_sel, ext_reject, frame_end;
  logic [47:0] da, station_addr;
  logic [63:0] mc_filter;
  logic        dec_valid, accept;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  rx_accept_filter #(.REJ_WIN(WIN)) u_rx_accept_filter (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da),
    .station_addr(station_addr), .mc_filter(mc_filter), .promisc(promisc),
    .no_bcast(no_bcast), .no_station(no_station), .ext_sel(ext_sel),
    .ext_reject(ext_reject), .frame_end(frame_end),
    .dec_valid(dec_valid), .accept(accept)
  );

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb = c[0] ^ a[i];
      c = {1'b0, c[31:1]};
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c;
  endfunction

  function automatic bit hash_hit(input logic [47:0] a);
    logic [31:0] c = ref_crc(a);
    return a[0] && mc_filter[c[31:26]];
  endfunction

  function automatic bit disabled_cfg();
    return !promisc && no_bcast && no_station && (mc_filter == 64'd0);
  endfunction

  function automatic bit exp_accept(input logic [47:0] a, input bit rej);
    bit hit = ((a == station_addr) && !no_station) || ((&a) && !no_bcast) || hash_hit(a);
    return promisc || hit || (ext_sel && disabled_cfg() && !rej);
  endfunction

  function automatic string pick_tag(input logic [47:0] a, input int rpos, input int fpos);
    if (promisc) return "R5";
    if ((a == station_addr) && !no_station) return ext_sel ? "R6" : "R2";
    if ((&a) && !no_bcast) return "R3";
    if (hash_hit(a)) return "R4";
    if (ext_sel && disabled_cfg()) return (rpos > WIN || rpos > fpos) ? "R8" : "R7";
    if (!ext_sel) return "R9";
    return "R10";
  endfunction

  task automatic check(input string tag, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, got, exp);
    end
  endtask

  // Reject at cycle rpos after the address edge (0 = none), frame end at fpos.
  task automatic run_frame(input logic [47:0] a, input int rpos, input int fpos, input string tag);
    bit rej = (rpos >= 1) && (rpos <= WIN) && (rpos <= fpos);
    bit e   = exp_accept(a, rej);
    @(negedge clk);
    da = a; da_valid = 1'b1; ext_reject = 1'b0; frame_end = 1'b0;
    @(posedge clk);
    for (int k = 1; k <= fpos; k++) begin
      @(negedge clk);
      da_valid = 1'b0; da = '0;
      ext_reject = (k == rpos);
      frame_end  = (k == fpos);
      @(posedge clk);
    end
    #1;
    check(tag, dec_valid, 1'b1, "verdict valid");
    check(tag, accept, e, "verdict");
    @(negedge clk);
    frame_end = 1'b0;
    ext_reject = (rpos > fpos);
    @(posedge clk);
    #1;
    check("R11", dec_valid, 1'b0, "valid is one cycle");
    @(negedge clk);
    ext_reject = 1'b0;
  endtask

  task automatic set_cfg(input bit p, input bit nb, input bit ns, input bit es, input logic [63:0] f);
    promisc = p; no_bcast = nb; no_station = ns; ext_sel = es; mc_filter = f;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [47:0] a;
    void'($urandom(32'd4242));
    rst_n = 1'b0; da_valid = 0; da = '0; ext_reject = 0; frame_end = 0;
    station_addr = 48'h0A1B2C3D4E50;
    set_cfg(0, 0, 0, 0, 64'd0);
    repeat (3) @(posedge clk);
    #1;
    check("R1", dec_valid, 1'b0, "valid in reset");
    check("R1", accept, 1'b0, "accept in reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1", dec_valid, 1'b0, "valid after reset");

    // Directed corner cases
    set_cfg(0, 0, 1, 0, 64'd0);
    run_frame(station_addr, 0, 2, "R2");           // station match suppressed
    set_cfg(0, 1, 0, 1, 64'd0);
    run_frame(48'hFFFF_FFFF_FFFF, 0, 2, "R3");     // broadcast suppressed
    run_frame(station_addr, 1, 3, "R6");           // internal match beats reject
    set_cfg(0, 1, 1, 1, 64'd0);
    run_frame(48'h123456789AB0, 2, 4, "R7");       // rejected inside window
    run_frame(48'h123456789AB0, 0, 4, "R7");       // accepted, no reject
    run_frame(48'h123456789AB0, WIN, WIN, "R8");   // last window cycle counts
    run_frame(48'h123456789AB0, WIN + 1, WIN + 3, "R8"); // after window
    run_frame(48'h123456789AB0, 5, 3, "R8");       // after frame end
    set_cfg(0, 1, 1, 0, 64'd0);
    run_frame(48'h123456789AB0, 1, 2, "R9");
    set_cfg(1, 1, 1, 1, 64'd0);
    run_frame(48'h123456789AB0, 1, 2, "R5");
    set_cfg(0, 1, 1, 1, 64'd1);
    run_frame(48'h123456789AB0, 0, 2, "R10");
    a = 48'h5A5A5A5A5A01;
    set_cfg(0, 1, 1, 0, 64'd0);
    mc_filter[ref_crc(a)[31:26]] = 1'b1;
    run_frame(a, 0, 2, "R4");
    run_frame({a[47:1], 1'b0}, 0, 2, "R4");        // unicast never hashes

    // Collision 1: end of a matching frame, next address and reject together
    set_cfg(0, 1, 0, 1, 64'd0);
    @(negedge clk); da = station_addr; da_valid = 1;
    @(posedge clk);
    @(negedge clk); da_valid = 0;
    @(posedge clk);
    @(negedge clk); da = 48'h00_11_22_33_44_56; da_valid = 1; frame_end = 1; ext_reject = 1;
    @(posedge clk); #1;
    check("R11", dec_valid, 1'b1, "collision verdict valid");
    check("R11", accept, 1'b1, "collision verdict of ending frame");
    @(negedge clk); da_valid = 0; frame_end = 0; ext_reject = 0;
    @(posedge clk);
    @(negedge clk); frame_end = 1;
    @(posedge clk); #1;
    check("R10", accept, 1'b0, "next frame judged alone");
    @(negedge clk); frame_end = 0;

    // Collision 2: externally judged frame ends after its window, reject at new address edge
    set_cfg(0, 1, 1, 1, 64'd0);
    @(negedge clk); da = 48'h00_11_22_33_44_58; da_valid = 1;
    @(posedge clk);
    for (int k = 1; k < WIN + 2; k++) begin
      @(negedge clk); da_valid = 0;
      @(posedge clk);
    end
    @(negedge clk); da = 48'h00_11_22_33_44_5A; da_valid = 1; frame_end = 1; ext_reject = 1;
    @(posedge clk); #1;
    check("R8", accept, 1'b1, "closed window ignores reject");
    @(negedge clk); da_valid = 0; frame_end = 1; ext_reject = 0;
    @(posedge clk); #1;
    check("R8", accept, 1'b1, "reject at address edge ignored");
    @(negedge clk); frame_end = 0;

    // Constrained random frames
    for (int n = 0; n < 300; n++) begin
      int sel = $urandom % 10;
      int rpos, fpos;
      if ($urandom % 3 == 0) set_cfg(0, 1, 1, $urandom % 2, 64'd0);
      else set_cfg(($urandom % 6) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
                   ($urandom % 4 == 0) ? 64'd0 : {$urandom, $urandom});
      if (sel < 3) a = station_addr;
      else if (sel < 4) a = '1;
      else a = {$urandom, $urandom};
      rpos = ($urandom % 3 == 0) ? 0 : 1 + ($urandom % (WIN + 3));
      fpos = 1 + ($urandom % (WIN + 4));
      run_frame(a, rpos, fpos, pick_tag(a, rpos, fpos));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule